// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Overlapped Grant Hand-Off

This block decides which of several bus masters may drive a shared, multiplexed parallel bus next. Each master has its own active-low request input and its own active-low grant output. When more than one master asks for the bus, the winner is chosen by a rotating priority, so that no master is starved.

Arbitration runs in parallel with the transfer already on the bus. The arbiter watches the bus framing and initiator-ready strobes, both active low. From them it learns when the granted master has actually taken the bus. It can then pass the grant to the next requester while that transfer is still running. The next owner therefore begins as soon as the bus goes idle, and no clock is spent on arbitration.

A master that is granted but has not yet started keeps its grant for as long as it keeps requesting. If it gives up before starting, the grant is withdrawn. A master that has started and leaves no one else asking keeps the grant, which parks the bus on it.

Top module: `pci_rr_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, every GNT# output is high. The rotating pointer starts at master 0, so the first contest after reset goes to the lowest-numbered requester.
- R2: At most one GNT# output is low in any cycle.
- R3: When no master holds a grant and exactly one REQ# is low at a rising edge, that master's GNT# is low from that edge on.
- R4: Bit i of `req_n` and of `gnt_n` belongs to master i. A new grant goes to the first requesting master found by counting upward from the pointer, wrapping from the top index to 0. Each new grant moves the pointer to the master one above the winner, also wrapping.
- R5: A granted master that keeps REQ# low keeps its grant until it has started a transfer, whatever the other masters request.
- R6: A start is seen at a rising edge where FRAME# is low and, at the previous edge, FRAME# and IRDY# were both high. At that same edge the grant moves to the next requester chosen by R4, even though the bus is now busy. If the owner is the only requester, it keeps the grant.
- R7: If a granted master that has not started releases REQ#, then at the next edge the grant passes to the R4 winner among the others, or to nobody if no other master requests.
- R8: Once the owner has started and no REQ# is low, the grant stays on that owner, both while the bus is busy and after it goes idle.
- R9: A FRAME# low that belongs to a transfer already in progress (no idle edge before it) is not a start for a master granted during that transfer. That master keeps its grant, per R5, until it starts after an idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_MST | Per-master bus request, active low |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| gnt_n | output | NUM_MST | Per-master bus grant, active low, registered |

## Verification
Two functions can land on the same rising edge. One is detecting that the current owner has started; the other is re-arbitrating to hand the grant to the next requester. The bench provokes this by lowering FRAME# after an idle edge while a different pattern of requests is presented at the same edge. For every owner and every request pattern, it checks that the grant moves at that edge to the master predicted by counting upward from the pointer. A second clash comes from an owner that drops its request on the same edge that others raise theirs. Here the bench judges whether the grant is withdrawn to the correct rival, or kept because the owner is still asking. A long pseudo-random run then compares every cycle against a cycle model kept in the bench.

// File: rtl/pci_rr_arb_pkg.sv
package pci_rr_arb_pkg;

  // What the grant register does at the next rising edge
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,  // owner (or no owner) unchanged
    ACT_GRANT = 2'd1,  // hand the grant to the picked winner
    ACT_CLEAR = 2'd2   // withdraw every grant
  } arb_act_e;

endpackage

// File: rtl/pci_rr_arb_busmon.sv
// Watches the bus strobes and flags the edge at which a fresh transfer begins.
module pci_rr_arb_busmon (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic start_o
);

  logic idle_q;  // bus was idle at the previous rising edge

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b1;
    end else begin
      idle_q <= frame_n & irdy_n;
    end
  end

  // R6/R9: FRAME# low only counts as a start when the bus was idle before
  assign start_o = idle_q & ~frame_n;

endmodule

// File: rtl/pci_rr_arb_pick.sv
// Rotating-priority picker: first requester counting upward from ptr_i.
module pci_rr_arb_pick #(
  parameter int NUM_MST = 3,
  parameter int IDXW    = 2
) (
  input  logic [NUM_MST-1:0] req_i,
  input  logic [IDXW-1:0]    ptr_i,
  output logic               any_o,
  output logic [IDXW-1:0]    win_o
);

  localparam logic [IDXW:0] NUM_W = (IDXW+1)'(NUM_MST);

  // R4: scan from the farthest offset down so the nearest requester wins
  always_comb begin
    logic [IDXW:0] slot;
    any_o = 1'b0;
    win_o = '0;
    for (int k = NUM_MST - 1; k >= 0; k--) begin
      slot = {1'b0, ptr_i} + (IDXW+1)'(k);
      if (slot >= NUM_W) begin
        slot = slot - NUM_W;
      end
      if (req_i[slot[IDXW-1:0]]) begin
        any_o = 1'b1;
        win_o = slot[IDXW-1:0];
      end
    end
  end

endmodule

// File: rtl/pci_rr_arb_ctl.sv
// Owner tracking, pointer rotation and the registered grant outputs.
module pci_rr_arb_ctl
  import pci_rr_arb_pkg::*;
#(
  parameter int NUM_MST = 3,
  parameter int IDXW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] req_i,
  input  logic               any_i,
  input  logic [IDXW-1:0]    win_i,
  input  logic               start_i,
  output logic [IDXW-1:0]    ptr_o,
  output logic [NUM_MST-1:0] gnt_n_o
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_MST - 1);

  logic               own_vld_q;
  logic [IDXW-1:0]    own_idx_q;
  logic [IDXW-1:0]    ptr_q;
  logic               started_q;
  logic [NUM_MST-1:0] gnt_n_q;

  logic               started_eff;
  logic [NUM_MST-1:0] win_oh;
  logic [IDXW-1:0]    ptr_nxt;
  arb_act_e           act;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MST; gi++) begin : g_win_oh
      assign win_oh[gi] = (win_i == IDXW'(gi));
    end
  endgenerate

  assign ptr_nxt = (win_i == LAST_IDX) ? '0 : win_i + 1'b1;

  always_comb begin
    started_eff = started_q | (start_i & own_vld_q);
    act         = ACT_KEEP;
    if (!own_vld_q) begin
      act = any_i ? ACT_GRANT : ACT_KEEP;                 // R3
    end else if (!started_eff) begin
      if (req_i[own_idx_q]) begin
        act = ACT_KEEP;                                   // R5, R9
      end else begin
        act = any_i ? ACT_GRANT : ACT_CLEAR;              // R7
      end
    end else begin
      // R6: hidden hand-off; R8: park when nobody else asks
      act = (any_i && (win_i != own_idx_q)) ? ACT_GRANT : ACT_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
      ptr_q     <= '0;                                    // R1
      started_q <= 1'b0;
      gnt_n_q   <= '1;
    end else begin
      unique case (act)
        ACT_GRANT: begin
          own_vld_q <= 1'b1;
          own_idx_q <= win_i;
          ptr_q     <= ptr_nxt;                           // R4
          started_q <= 1'b0;
          gnt_n_q   <= ~win_oh;
        end
        ACT_CLEAR: begin
          own_vld_q <= 1'b0;
          started_q <= 1'b0;
          gnt_n_q   <= '1;
        end
        default: begin
          started_q <= started_eff & own_vld_q;
        end
      endcase
    end
  end

  assign ptr_o   = ptr_q;
  assign gnt_n_o = gnt_n_q;

endmodule

// File: rtl/pci_rr_arb.sv
// Top: rotating-priority grant arbiter with overlapped hand-off.
module pci_rr_arb #(
  parameter int NUM_MST = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] req_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic [NUM_MST-1:0] gnt_n
);

  localparam int IDXW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  logic [NUM_MST-1:0] req;
  logic               any;
  logic [IDXW-1:0]    win;
  logic [IDXW-1:0]    ptr;
  logic               start;

  assign req = ~req_n;

  pci_rr_arb_busmon u_busmon (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .start_o (start)
  );

  pci_rr_arb_pick #(
    .NUM_MST (NUM_MST),
    .IDXW    (IDXW)
  ) u_pick (
    .req_i (req),
    .ptr_i (ptr),
    .any_o (any),
    .win_o (win)
  );

  pci_rr_arb_ctl #(
    .NUM_MST (NUM_MST),
    .IDXW    (IDXW)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .any_i   (any),
    .win_i   (win),
    .start_i (start),
    .ptr_o   (ptr),
    .gnt_n_o (gnt_n)
  );

endmodule

// File: rtl/pci_rr_arb_chk.sv
module pci_rr_arb_chk #(
  parameter int NUM_MST = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_MST-1:0] req_n,
  input logic [NUM_MST-1:0] gnt_n
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n)); // R2

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&gnt_n)); // R1

  AST_LONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    ((&gnt_n) && $onehot(~req_n)) |=> (gnt_n == $past(req_n))); // R3

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (rst)
    (&req_n) |=> ((&gnt_n) || $stable(gnt_n))); // R8

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MST; gi++) begin : g_per_mst
      AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        $fell(gnt_n[gi]) |-> $past(!req_n[gi])); // R4
    end
  endgenerate

endmodule

bind pci_rr_arb pci_rr_arb_chk #(.NUM_MST(NUM_MST)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req_n (req_n),
  .gnt_n (gnt_n)
);

// File: tb/pci_rr_arb_tb.sv
module pci_rr_arb_tb;

  localparam int NM = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] req_n = '1;
  logic          frame_n = 1'b1;
  logic          irdy_n = 1'b1;
  logic [NM-1:0] gnt_n;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  int m_own;
  int m_ptr;
  bit m_started;
  bit m_idle;

  always #5 clk = ~clk;

  pci_rr_arb #(.NUM_MST(NM)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): run still active, expected completion");
    summary();
    $finish;
  end

  // drive at the falling edge, then look just after the next rising edge
  task automatic cyc(input logic [NM-1:0] rq, input logic f, input logic i);
    @(negedge clk);
    req_n   = ~rq;
    frame_n = f;
    irdy_n  = i;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst     = 1'b1;
    req_n   = '1;
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_own = -1; m_ptr = 0; m_started = 1'b0; m_idle = 1'b1;
  endtask

  task automatic expect_gnt(input int who, input string tag);
    logic [NM-1:0] exp;
    exp = (who < 0) ? '1 : ~(NM'(1) << who);
    n_chk++;
    if (gnt_n !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt_n=%b expected %b", tag, gnt_n, exp);
    end
  endtask

  function automatic int first_from(input logic [NM-1:0] p, input int s);
    for (int k = 0; k < NM; k++) begin
      if (p[(s + k) % NM]) return (s + k) % NM;
    end
    return -1;
  endfunction

  // cycle model of the requirements, stepped with the same inputs as the DUT
  task automatic ref_step(input logic [NM-1:0] rq, input logic f, input logic i);
    bit st;
    int w;
    st = m_started || (m_idle && !f && m_own >= 0);
    w  = first_from(rq, m_ptr);
    if (m_own < 0) begin
      if (w >= 0) begin m_own = w; m_ptr = (w + 1) % NM; m_started = 0; end
    end else if (!st) begin
      if (!rq[m_own]) begin
        if (w >= 0) begin m_own = w; m_ptr = (w + 1) % NM; end
        else m_own = -1;
        m_started = 0;
      end
    end else begin
      if (w >= 0 && w != m_own) begin
        m_own = w; m_ptr = (w + 1) % NM; m_started = 0;
      end else m_started = 1;
    end
    m_idle = f && i;
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [NM-1:0] rq;
    logic f, i;

    // R1: reset state
    @(posedge clk); #2;
    expect_gnt(-1, "R1 during reset");
    do_reset();
    @(posedge clk); #2;
    expect_gnt(-1, "R1 after reset release");

    // R4/R1/R3: every pattern straight after reset, pointer at master 0
    for (int p = 0; p < (1 << NM); p++) begin
      do_reset();
      cyc(NM'(p), 1'b1, 1'b1);
      expect_gnt(first_from(NM'(p), 0), "R4 first contest from pointer 0 (R3 when lone)");
    end

    // R6: start edge and hand-off on the same edge, all owners x all patterns
    for (int j = 0; j < NM; j++) begin
      for (int p = 1; p < (1 << NM); p++) begin
        do_reset();
        cyc(NM'(1) << j, 1'b1, 1'b1);
        expect_gnt(j, "R3 lone request");
        cyc(NM'(p), 1'b0, 1'b1);
        expect_gnt(first_from(NM'(p), (j + 1) % NM), "R6 hidden hand-off at start");
      end
    end

    // R5/R7: owner not started, request change on an idle bus
    for (int j = 0; j < NM; j++) begin
      for (int p = 0; p < (1 << NM); p++) begin
        do_reset();
        cyc(NM'(1) << j, 1'b1, 1'b1);
        cyc(NM'(p), 1'b1, 1'b1);
        if (p[j]) expect_gnt(j, "R5 unstarted owner keeps grant");
        else      expect_gnt(first_from(NM'(p), (j + 1) % NM), "R7 withdraw from unstarted owner");
      end
    end

    // R8: parking on a started owner, then hand-off to a newcomer
    for (int j = 0; j < NM; j++) begin
      do_reset();
      cyc(NM'(1) << j, 1'b1, 1'b1);
      cyc(NM'(1) << j, 1'b0, 1'b1);
      expect_gnt(j, "R6 lone owner keeps grant at start");
      cyc('0, 1'b0, 1'b0);
      expect_gnt(j, "R8 park while busy");
      cyc('0, 1'b1, 1'b1);
      expect_gnt(j, "R8 park while idle");
      cyc(NM'(1) << ((j + 2) % NM), 1'b1, 1'b1);
      expect_gnt((j + 2) % NM, "R4 newcomer after park");
    end

    // R9: continuing transfer is not a start for a master granted mid-transfer
    do_reset();
    cyc(3'b001, 1'b1, 1'b1);
    expect_gnt(0, "R3 master 0");
    cyc(3'b011, 1'b0, 1'b1);
    expect_gnt(1, "R6 hand-off to master 1 while busy");
    cyc(3'b110, 1'b0, 1'b0);
    expect_gnt(1, "R9 no false start during running transfer");
    cyc(3'b110, 1'b1, 1'b1);
    expect_gnt(1, "R5 held through idle edge");
    cyc(3'b110, 1'b0, 1'b1);
    expect_gnt(2, "R6 master 1 starts, grant moves to 2");

    // pseudo-random sweep against the cycle model (R2, R4 and the rest)
    do_reset();
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq = lfsr[NM-1:0];
      f  = lfsr[4];
      i  = lfsr[5] | lfsr[6];
      cyc(rq, f, i);
      ref_step(rq, f, i);
      expect_gnt(m_own, "R4 sweep vs model");
      n_chk++;
      if ($countones(~gnt_n) > 1) begin
        n_fail++;
        $display("FAIL R2: gnt_n=%b expected at most one low", gnt_n);
      end
    end

    summary();
    $finish;
  end

endmodule